// File: doc/BRIEF.md
# Serial Configuration Readback Controller

This block sends the stored configuration frames of a device, plus one frame of captured internal state, out through a single serial pin. It is clocked by the configuration clock and is driven by an active-low read request. A qualified falling edge on the request starts a readback. After a fixed latency, the controller emits every frame word held in a small frame memory, in address order. It then emits one frame built from a bank of capture registers. Each frame is wrapped in a low start bit and a high stop bit. No header of any kind comes before the first frame.

A two-bit permission input limits how often readback may happen: never, once after reset, or without limit. A two-bit capture mode selects when the capture registers load the internal state word. Before the configuration-done input is raised, the request pin acts only as a global tri-state control and readback stays disabled. The frame memory is filled through a simple write port, which models configuration loading.

Top module: `cfg_readback_ctrl`

## Requirements
- R1: A readback starts only at a clock edge that samples `rd_req_n` low when the two edges before it sampled it high. The first start bit is on `ser_out` exactly LAT (default 3) edges after that starting edge. `rb_active` is high from the starting edge until the stream ends.
- R2: One bit leaves per rising edge. Each frame is a 0 start bit, FRAME_W data bits sent LSB first and not inverted, then a 1 stop bit. Frames follow back to back: memory words at addresses 0 to NUM_FRAMES-1 in that order, then the capture frame. No preamble comes before them.
- R3: At the edge after the last stop bit, `rb_done` rises, `rb_active` falls and `ser_out` stays high. `rb_done` clears at the first edge that samples the request high.
- R4: An edge that samples `rd_req_n` high during a readback pauses it: `ser_out` is 1 and `rb_active` is 0 at that edge. If the next edge samples the request low again, the stream resumes with the very bit that was pending. If the request stays high for two or more edges before going low, the readback restarts from frame 0.
- R5: Permission encoding: 2'b00 never emits any data. 2'b01 allows a single readback after reset, and later requests leave the pin idle. 2'b10 and 2'b11 allow any number of readbacks.
- R6: The single allowance of mode 2'b01 is used up only when a start bit is emitted. A request withdrawn before its first start bit can be repeated and then succeeds.
- R7: Capture mode 2'b00 leaves the capture registers unchanged (reset value 0). 2'b01 loads `state_in` at the edge that starts a readback. 2'b10 loads `state_in` at every edge where `cap_hold` is 0. 2'b11 loads on either condition.
- R8: While `cfg_done` is 0, no readback runs, and `gts_out` shows at the next edge whether `rd_req_n` is low (1 when it is low). While `cfg_done` is 1, `gts_out` is 0.
- R9: After synchronous reset, `ser_out` is 1, `rb_active`, `rb_done` and `gts_out` are 0, the capture registers hold 0 and the one-shot allowance is unused.
- R10: Whenever `rb_active` is 0, `ser_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_done | input | 1 | Configuration complete; enables readback |
| rd_req_n | input | 1 | Active-low read request |
| perm_mode | input | 2 | Readback permission setting |
| cap_mode | input | 2 | Capture trigger mode |
| cap_hold | input | 1 | Internal capture gate; 0 allows gated capture |
| state_in | input | FRAME_W | Internal state word to capture |
| cfg_wr_en | input | 1 | Frame memory write enable |
| cfg_wr_addr | input | clog2(NUM_FRAMES) | Frame memory write address |
| cfg_wr_data | input | FRAME_W | Frame memory write data |
| ser_out | output | 1 | Serial readback data |
| rb_active | output | 1 | Readback in progress and not paused |
| rb_done | output | 1 | Whole stream has been sent |
| gts_out | output | 1 | Global tri-state request before configuration completes |

## Verification
The bench checks the whole bit stream, bit by bit, against a model built from the frame formula. A wrong latency, a swapped bit order, inverted data or a missing stop bit therefore shows up as a mismatch at a known stream index. It inserts a one-edge request blip during the latency wait and again in mid-frame. A design that resets the frame pointer on too short a high period would restart at frame 0 there, and one that loses the pending bit would drift by one. It runs a restart after exactly two high edges, the one-shot retry after an abort inside the latency window, and all capture modes with `state_in` changed just after the start edge. These catch a permission counter consumed at the request edge and a capture frame latched at the wrong moment.

// File: rtl/rb_pkg.sv
package rb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_DONE  = 2'd3
  } rb_state_e;

  localparam logic [1:0] PERM_NONE  = 2'b00;
  localparam logic [1:0] PERM_ONCE  = 2'b01;

  localparam logic [1:0] CAP_NONE   = 2'b00;
endpackage

// File: rtl/rb_frame_ram.sv
module rb_frame_ram #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/rb_req_ctrl.sv
module rb_req_ctrl
  import rb_pkg::*;
#(
  parameter int HIGH_MIN = 2,
  localparam int HW      = $clog2(HIGH_MIN + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_done,
  input  logic       rd_req_n,
  input  logic [1:0] perm_mode,
  input  logic       sop,
  output logic       start_go,
  output logic       resume_go,
  output logic       kill_go,
  output logic       gts_out
);
  localparam logic [HW-1:0] HMAX = HW'(HIGH_MIN);

  logic          req_prev;
  logic [HW-1:0] hcnt;
  logic          used_q;
  logic          fall, long_high, permit;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_prev <= 1'b1;
      hcnt     <= '0;
      used_q   <= 1'b0;
      gts_out  <= 1'b0;
    end else begin
      req_prev <= rd_req_n;
      if (rd_req_n) begin
        if (hcnt != HMAX) hcnt <= hcnt + 1'b1;
      end else begin
        hcnt <= '0;
      end
      if (sop) used_q <= 1'b1;
      gts_out <= ~cfg_done & ~rd_req_n;
    end
  end

  assign fall      = req_prev & ~rd_req_n;
  assign long_high = (hcnt == HMAX);
  assign permit    = perm_mode[1] | ((perm_mode == PERM_ONCE) & ~used_q);
  assign start_go  = cfg_done & fall & long_high & permit;
  assign kill_go   = cfg_done & fall & long_high & ~permit;
  assign resume_go = cfg_done & fall & ~long_high;

  // R6
  used_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    used_q |=> used_q);
endmodule

// File: rtl/rb_capture.sv
module rb_capture
  import rb_pkg::*;
#(
  parameter int CAP_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cap_mode,
  input  logic             cap_hold,
  input  logic             enter,
  input  logic [CAP_W-1:0] state_in,
  output logic [CAP_W-1:0] cap_q
);
  logic load;

  assign load = (cap_mode[0] & enter) | (cap_mode[1] & ~cap_hold);

  always_ff @(posedge clk) begin
    if (rst)       cap_q <= '0;
    else if (load) cap_q <= state_in;
  end

  // R7
  cap_off_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_mode == CAP_NONE) |=> $stable(cap_q));
endmodule

// File: rtl/rb_serializer.sv
module rb_serializer
  import rb_pkg::*;
#(
  parameter int FRAME_W    = 16,
  parameter int NUM_FRAMES = 8,
  parameter int LAT        = 3,
  localparam int FW        = $clog2(NUM_FRAMES + 2),
  localparam int BW        = $clog2(FRAME_W + 2),
  localparam int LW        = $clog2(LAT + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               req_hi,
  input  logic               start_go,
  input  logic               resume_go,
  input  logic               kill_go,
  input  logic [FRAME_W-1:0] ram_word,
  input  logic [FRAME_W-1:0] cap_word,
  output logic [FW-1:0]      frm_idx,
  output logic               sop,
  output logic               ser_out,
  output logic               active_o,
  output logic               done_o
);
  localparam logic [FW-1:0] CAP_F  = FW'(NUM_FRAMES);
  localparam logic [FW-1:0] END_F  = FW'(NUM_FRAMES + 1);
  localparam logic [BW-1:0] LAST_D = BW'(FRAME_W);
  localparam logic [LW-1:0] WAIT0  = LW'(LAT - 1);

  rb_state_e          state;
  logic [LW-1:0]      wcnt;
  logic [BW-1:0]      bcnt;
  logic [FRAME_W-1:0] sh;
  logic               paused;
  logic               running, step;
  logic [FRAME_W-1:0] word;

  assign running = (state == ST_WAIT) || (state == ST_SHIFT);
  assign step    = en & ~req_hi & ~start_go & ~kill_go & running & (~paused | resume_go);
  assign sop     = step & (((state == ST_WAIT) && (wcnt == '0)) ||
                           ((state == ST_SHIFT) && (bcnt == '0) && (frm_idx != END_F)));
  assign word    = (frm_idx == CAP_F) ? cap_word : ram_word;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state    <= ST_IDLE;
      wcnt     <= '0;
      bcnt     <= '0;
      frm_idx  <= '0;
      sh       <= '0;
      paused   <= 1'b0;
      ser_out  <= 1'b1;
      active_o <= 1'b0;
      done_o   <= 1'b0;
    end else if (start_go) begin
      state    <= ST_WAIT;
      wcnt     <= WAIT0;
      bcnt     <= '0;
      frm_idx  <= '0;
      paused   <= 1'b0;
      ser_out  <= 1'b1;
      active_o <= 1'b1;
      done_o   <= 1'b0;
    end else if (kill_go) begin
      state    <= ST_IDLE;
      paused   <= 1'b0;
      ser_out  <= 1'b1;
      active_o <= 1'b0;
      done_o   <= 1'b0;
    end else if (req_hi) begin
      ser_out  <= 1'b1;
      active_o <= 1'b0;
      if (running) paused <= 1'b1;
      if (state == ST_DONE) begin
        state  <= ST_IDLE;
        done_o <= 1'b0;
      end
    end else if (step) begin
      paused   <= 1'b0;
      active_o <= 1'b1;
      if (state == ST_WAIT) begin
        if (wcnt != '0) begin
          wcnt <= wcnt - 1'b1;
        end else begin
          ser_out <= 1'b0;
          state   <= ST_SHIFT;
          bcnt    <= BW'(1);
        end
      end else if (bcnt == '0) begin
        if (frm_idx == END_F) begin
          state    <= ST_DONE;
          done_o   <= 1'b1;
          active_o <= 1'b0;
          ser_out  <= 1'b1;
        end else begin
          ser_out <= 1'b0;
          bcnt    <= BW'(1);
        end
      end else if (bcnt <= LAST_D) begin
        if (bcnt == BW'(1)) begin
          ser_out <= word[0];
          sh      <= word >> 1;
        end else begin
          ser_out <= sh[0];
          sh      <= sh >> 1;
        end
        bcnt <= bcnt + 1'b1;
      end else begin
        ser_out <= 1'b1;
        bcnt    <= '0;
        frm_idx <= frm_idx + 1'b1;
      end
    end
  end

  // R10
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !active_o |-> ser_out);

  // R3
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (ser_out && !active_o));
endmodule

// File: rtl/cfg_readback_ctrl.sv
module cfg_readback_ctrl
  import rb_pkg::*;
#(
  parameter int FRAME_W    = 16,
  parameter int NUM_FRAMES = 8,
  parameter int LAT        = 3,
  parameter int HIGH_MIN   = 2,
  localparam int AW        = $clog2(NUM_FRAMES),
  localparam int FW        = $clog2(NUM_FRAMES + 2)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_done,
  input  logic               rd_req_n,
  input  logic [1:0]         perm_mode,
  input  logic [1:0]         cap_mode,
  input  logic               cap_hold,
  input  logic [FRAME_W-1:0] state_in,
  input  logic               cfg_wr_en,
  input  logic [AW-1:0]      cfg_wr_addr,
  input  logic [FRAME_W-1:0] cfg_wr_data,
  output logic               ser_out,
  output logic               rb_active,
  output logic               rb_done,
  output logic               gts_out
);
  logic               start_go, resume_go, kill_go, sop;
  logic [FW-1:0]      frm_idx;
  logic [FRAME_W-1:0] ram_word, cap_word;

  rb_req_ctrl #(.HIGH_MIN(HIGH_MIN)) u_req (
    .clk       (clk),
    .rst       (rst),
    .cfg_done  (cfg_done),
    .rd_req_n  (rd_req_n),
    .perm_mode (perm_mode),
    .sop       (sop),
    .start_go  (start_go),
    .resume_go (resume_go),
    .kill_go   (kill_go),
    .gts_out   (gts_out)
  );

  rb_frame_ram #(.WORD_W(FRAME_W), .DEPTH(NUM_FRAMES)) u_ram (
    .clk     (clk),
    .wr_en   (cfg_wr_en),
    .wr_addr (cfg_wr_addr),
    .wr_data (cfg_wr_data),
    .rd_addr (frm_idx[AW-1:0]),
    .rd_data (ram_word)
  );

  rb_capture #(.CAP_W(FRAME_W)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .cap_mode (cap_mode),
    .cap_hold (cap_hold),
    .enter    (start_go),
    .state_in (state_in),
    .cap_q    (cap_word)
  );

  rb_serializer #(.FRAME_W(FRAME_W), .NUM_FRAMES(NUM_FRAMES), .LAT(LAT)) u_ser (
    .clk       (clk),
    .rst       (rst),
    .en        (cfg_done),
    .req_hi    (rd_req_n),
    .start_go  (start_go),
    .resume_go (resume_go),
    .kill_go   (kill_go),
    .ram_word  (ram_word),
    .cap_word  (cap_word),
    .frm_idx   (frm_idx),
    .sop       (sop),
    .ser_out   (ser_out),
    .active_o  (rb_active),
    .done_o    (rb_done)
  );

  // R8
  cfg_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_done |=> !rb_active);

  // R4
  req_high_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req_n |=> !rb_active);
endmodule

// File: tb/tb_cfg_readback_ctrl.sv
module tb_cfg_readback_ctrl;
  localparam int FRAME_W = 16;
  localparam int NF      = 8;
  localparam int LAT     = 3;
  localparam int FLEN    = FRAME_W + 2;
  localparam int TOTAL   = (NF + 1) * FLEN;
  localparam int AW      = $clog2(NF);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_done = 1'b0;
  logic rd_req_n = 1'b1;
  logic [1:0] perm_mode = 2'b11;
  logic [1:0] cap_mode = 2'b00;
  logic cap_hold = 1'b1;
  logic [FRAME_W-1:0] state_in = '0;
  logic cfg_wr_en = 1'b0;
  logic [AW-1:0] cfg_wr_addr = '0;
  logic [FRAME_W-1:0] cfg_wr_data = '0;
  logic ser_out, rb_active, rb_done, gts_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cfg_readback_ctrl #(.FRAME_W(FRAME_W), .NUM_FRAMES(NF), .LAT(LAT)) dut (
    .clk(clk), .rst(rst), .cfg_done(cfg_done), .rd_req_n(rd_req_n),
    .perm_mode(perm_mode), .cap_mode(cap_mode), .cap_hold(cap_hold),
    .state_in(state_in), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
    .cfg_wr_data(cfg_wr_data), .ser_out(ser_out), .rb_active(rb_active),
    .rb_done(rb_done), .gts_out(gts_out)
  );

  function automatic logic [FRAME_W-1:0] fword(input int f);
    return FRAME_W'((f * 16'h2F1B) ^ 16'h9C36 ^ (f << 11));
  endfunction

  function automatic logic exp_bit(input int k, input logic [FRAME_W-1:0] cap);
    int f, p;
    logic [FRAME_W-1:0] w;
    f = k / FLEN;
    p = k % FLEN;
    if (p == 0) return 1'b0;
    if (p == FLEN - 1) return 1'b1;
    w = (f == NF) ? cap : fword(f);
    return w[p-1];
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; rd_req_n = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic raise_req();
    @(negedge clk); rd_req_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // Drives the request low and checks every output at every edge.
  task automatic stream_check(input logic [FRAME_W-1:0] sb, input logic [FRAME_W-1:0] sa,
                              input logic [FRAME_W-1:0] ecap, input int blip_at,
                              input string rq);
    int t, bad, first_t;
    logic hi, eb, ea, ed;
    logic [2:0] got, want;
    t = 0; bad = 0; first_t = -1; hi = 1'b0; got = '0; want = '0;
    state_in = sb;
    @(negedge clk); rd_req_n = 1'b0;
    while (t <= LAT + TOTAL) begin
      @(negedge clk);
      if (hi) begin
        eb = 1'b1; ea = 1'b0; ed = 1'b0;
      end else begin
        eb = (t < LAT) ? 1'b1 : ((t - LAT < TOTAL) ? exp_bit(t - LAT, ecap) : 1'b1);
        ea = (t < LAT + TOTAL);
        ed = (t == LAT + TOTAL);
        t++;
      end
      if (ser_out !== eb || rb_active !== ea || rb_done !== ed) begin
        if (bad == 0) begin
          first_t = t;
          got  = {ser_out, rb_active, rb_done};
          want = {eb, ea, ed};
        end
        bad++;
      end
      if (t == 1) state_in = sa;
      hi = (t == blip_at) && !hi;
      rd_req_n = hi;
    end
    chk(bad == 0, rq, $sformatf("stream {ser,act,done} at step %0d", first_t),
        32'(got), 32'(want));
    @(negedge clk);
    chk(rb_done === 1'b1 && ser_out === 1'b1, "R3", "done held while low",
        {30'd0, rb_done, ser_out}, 32'd3);
    @(negedge clk); rd_req_n = 1'b1;
    @(negedge clk);
    chk(rb_done === 1'b0, "R3", "done cleared by high request", 32'(rb_done), 32'd0);
    @(negedge clk);
  endtask

  task automatic expect_silent(input int n, input string rq);
    int bad;
    bad = 0;
    @(negedge clk); rd_req_n = 1'b0;
    repeat (n) begin
      @(negedge clk);
      if (ser_out !== 1'b1 || rb_active !== 1'b0) bad++;
    end
    chk(bad == 0, rq, "pin idle, no readback", 32'(bad), 32'd0);
    raise_req();
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(ser_out === 1'b1 && rb_active === 1'b0 && rb_done === 1'b0 && gts_out === 1'b0,
        "R9", "reset outputs", {28'd0, ser_out, rb_active, rb_done, gts_out}, 32'h8);

    for (int f = 0; f < NF; f++) begin
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_wr_addr = AW'(f); cfg_wr_data = fword(f);
    end
    @(negedge clk); cfg_wr_en = 1'b0;

    // R8: before configuration completes the request only drives gts_out
    do_reset();
    perm_mode = 2'b11;
    @(negedge clk); rd_req_n = 1'b0;
    @(negedge clk);
    chk(gts_out === 1'b1, "R8", "gts_out with request low", 32'(gts_out), 32'd1);
    repeat (30) begin
      @(negedge clk);
      chk(ser_out === 1'b1 && rb_active === 1'b0, "R8", "no readback before done",
          {30'd0, ser_out, rb_active}, 32'd2);
    end
    @(negedge clk); rd_req_n = 1'b1;
    @(negedge clk);
    chk(gts_out === 1'b0, "R8", "gts_out with request high", 32'(gts_out), 32'd0);
    cfg_done = 1'b1;
    @(negedge clk); rd_req_n = 1'b0;
    @(negedge clk);
    chk(gts_out === 1'b0, "R8", "gts_out after config done", 32'(gts_out), 32'd0);
    raise_req();

    // R1 R2 R3 R7: unlimited mode, no capture, state_in ignored
    do_reset();
    cap_mode = 2'b00;
    stream_check(16'hBEEF, 16'hF00D, 16'h0000, -1, "R1 R2 R7");
    perm_mode = 2'b10;
    stream_check(16'h1111, 16'h2222, 16'h0000, -1, "R5 repeat");

    // R4 short blips: during the latency wait and in mid-frame
    stream_check(16'h0, 16'h0, 16'h0000, 1, "R4 blip wait");
    stream_check(16'h0, 16'h0, 16'h0000, 40, "R4 blip mid");
    stream_check(16'h0, 16'h0, 16'h0000, 3, "R4 blip at start bit");

    // R4 long pause restarts from frame 0
    @(negedge clk); rd_req_n = 1'b0;
    repeat (60) @(negedge clk);
    raise_req();
    stream_check(16'h0, 16'h0, 16'h0000, -1, "R4 restart");

    // R7 capture modes
    cap_mode = 2'b01; cap_hold = 1'b1;
    stream_check(16'h1234, 16'h5678, 16'h1234, -1, "R7 entry");
    cap_mode = 2'b10; cap_hold = 1'b0;
    stream_check(16'h1234, 16'h5678, 16'h5678, -1, "R7 gated open");
    @(negedge clk); cap_hold = 1'b1;
    stream_check(16'hAAAA, 16'h5555, 16'h5678, -1, "R7 gated closed");
    cap_mode = 2'b11;
    stream_check(16'hC3C3, 16'h3C3C, 16'hC3C3, -1, "R7 either entry");
    cap_hold = 1'b0;
    stream_check(16'h0F0F, 16'hF0F0, 16'hF0F0, -1, "R7 either gated");
    cap_mode = 2'b00; cap_hold = 1'b1;

    // R5 prohibit
    do_reset();
    perm_mode = 2'b00;
    expect_silent(200, "R5 prohibit");

    // R6 one-shot: abort before output, retry succeeds, later ignored
    do_reset();
    perm_mode = 2'b01;
    @(negedge clk); rd_req_n = 1'b0;
    repeat (2) @(negedge clk);
    raise_req();
    stream_check(16'h0, 16'h0, 16'h0000, -1, "R6 retry after abort");
    expect_silent(200, "R5 R6 one-shot used");
    perm_mode = 2'b11;
    stream_check(16'h0, 16'h0, 16'h0000, -1, "R5 unlimited after one-shot");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule